// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of wide words by a fixed number of clock cycles. A chain of flip-flops would do the same, but it grows costly once the delay reaches tens or hundreds of stages. Here the words stay put in a dual-port memory, and two address counters move instead. Every cycle one word is written at the write address and one word is read at the read address. Both addresses then step forward by one and wrap around the power-of-two depth.

There is no address input and no handshake. The block accepts a word on every rising clock edge while reset is released and returns the word it took exactly `DEPTH` cycles earlier. A one-bit flag marks the output as meaningful once the memory has been filled for the first time after reset. Data width and depth (as a power of two) are parameters. The fixed latency is exposed as the localparam `LATENCY`, which equals `DEPTH`.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears itself. The read address becomes 0, the write address becomes all ones (`DEPTH-1`), `dout` becomes 0 and `dout_valid` becomes 0.
- R2: On every rising edge with `rst_n` high, one word is written and one word is read. Both addresses advance by one, and each wraps from `DEPTH-1` to 0.
- R3: The read address is always exactly one entry ahead of the write address, modulo `DEPTH`.
- R4: A word sampled on `din` at one rising edge appears on `dout` after exactly `DEPTH` further rising edges (`LATENCY` = `DEPTH`).
- R5: After reset is released, `dout_valid` stays low through the first `DEPTH` rising edges. It goes high after edge number `DEPTH`, counting from 0 at the first edge with `rst_n` high, and then stays high until the next reset.
- R6: A reset applied in the middle of a stream drops `dout_valid` and restarts the fill count. No word sampled before that reset is ever presented with `dout_valid` high.
- R7: While `dout_valid` is high, `dout` matches a flip-flop shift register of `DEPTH` stages fed with the same input. This holds over several wraps of the memory and for any data pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DATA_W | Word accepted on every rising edge while out of reset |
| dout | output | DATA_W | Word accepted `DEPTH` edges earlier |
| dout_valid | output | 1 | High once `dout` carries data written since the last reset |

## Verification
The assertions assume that `rst_n` is low from time zero and is held low for at least one rising edge before it is released. Their pointer and timing checks count edges only from that first reset onward. The stimulus starts in reset, always holds reset low across several edges, and drives a new word on every cycle with no gaps. As a result, the bench's expected queue and the fill count it keeps move in step with the counters the assertions rely on.

// File: rtl/dl_pkg.sv
// Package: shared helpers for the memory-backed delay line.
// Assumes: sizes are passed as unsigned integers known at elaboration.
package dl_pkg;

    // Width of a counter that must hold every value from 0 up to limit.
    function automatic int unsigned count_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/dl_ptr_counter.sv
// Module: free-running address counter with a programmable reset value.
// Assumes: the depth is 2**AW, so the counter wraps by plain overflow.
module dl_ptr_counter #(
    parameter int unsigned AW = 5,
    parameter logic [AW-1:0] START = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] ptr
);

    // Load START in reset, otherwise step by one each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= START;
        else        ptr <= ptr + AW'(1);
    end

endmodule

// File: rtl/dl_dual_port_mem.sv
// Module: simple dual-port storage with one write port and one registered read port.
// Assumes: read and write addresses never match in the same cycle, so the
// read-during-write ordering does not matter. The contents are not reset.
module dl_dual_port_mem #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 5,
    localparam int unsigned ENTRIES = 1 << AW
) (
    input  logic          clk,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] store [ENTRIES];

    // Write the incoming word every cycle.
    always_ff @(posedge clk) begin
        store[wr_addr] <= wr_data;
    end

    // Register the word at the read address.
    always_ff @(posedge clk) begin
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/dl_fill_tracker.sv
// Module: counts edges since reset and raises a sticky flag once the
// delay line has produced its first word written after reset.
// Assumes: one word enters on every edge out of reset.
module dl_fill_tracker #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CW = dl_pkg::count_width(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    output logic filled
);

    logic [CW-1:0] edge_cnt;
    logic          at_limit;

    always_comb at_limit = (edge_cnt == CW'(DEPTH));

    // Count edges since reset, saturating at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)         edge_cnt <= '0;
        else if (!at_limit) edge_cnt <= edge_cnt + CW'(1);
    end

    // Raise the flag on edge DEPTH and hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) filled <= 1'b0;
        else        filled <= filled | at_limit;
    end

endmodule

// File: rtl/ram_delay_line.sv
// Module: fixed delay line of DEPTH cycles kept in a dual-port memory.
// The write address starts at the last entry and the read address at the
// first. Both step every cycle, so a word is read back DEPTH-1 edges after
// it is written. The registered read and one output stage bring the total
// latency to exactly DEPTH edges.
// Assumes: a word is presented on every cycle; ADDR_W >= 1.
module ram_delay_line #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned DEPTH = 1 << ADDR_W,
    localparam int unsigned LATENCY = DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);

    localparam logic [ADDR_W-1:0] RD_START = '0;
    localparam logic [ADDR_W-1:0] WR_START = '1;

    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;
    logic [DATA_W-1:0] mem_q;

    dl_ptr_counter #(.AW(ADDR_W), .START(RD_START)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (rd_ptr)
    );

    dl_ptr_counter #(.AW(ADDR_W), .START(WR_START)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (wr_ptr)
    );

    dl_dual_port_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_addr (wr_ptr),
        .wr_data (din),
        .rd_addr (rd_ptr),
        .rd_data (mem_q)
    );

    dl_fill_tracker #(.DEPTH(LATENCY)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .filled (dout_valid)
    );

    // Output stage: a known zero in reset, the read word otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= mem_q;
    end

endmodule

// File: rtl/ram_delay_line_chk.sv
// Checker: properties of the delay line's addresses and valid flag.
// Assumes: rst_n is low from time zero for at least one edge.
module ram_delay_line_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned DEPTH = 1 << ADDR_W,
    localparam int unsigned CW = dl_pkg::count_width(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid
);

    logic          armed;
    logic [CW-1:0] cyc;
    logic [ADDR_W-1:0] gap;

    // Mark that at least one edge has passed with reset released.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    // Count edges since reset, saturating just past DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cyc <= '0;
        else if (cyc != CW'(DEPTH + 1)) cyc <= cyc + CW'(1);
    end

    always_comb gap = rd_ptr - wr_ptr;

    // R1: reset values are visible at the first edge after release.
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (rd_ptr == '0 && wr_ptr == '1 && dout == '0 && !dout_valid));

    // R2: the read address steps by one with wrap.
    a_r2_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (rd_ptr == $past(rd_ptr) + ADDR_W'(1)));

    // R2: the write address steps by one with wrap.
    a_r2_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (wr_ptr == $past(wr_ptr) + ADDR_W'(1)));

    // R3: the read address leads the write address by one entry.
    a_r3_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
        gap == ADDR_W'(1));

    // R5: the flag rises only after DEPTH edges since release.
    a_r5_valid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid == (cyc == CW'(DEPTH + 1)));

    // R5: once high, the flag holds until reset.
    a_r5_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> dout_valid);

endmodule

bind ram_delay_line ram_delay_line_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ptr     (rd_ptr),
    .wr_ptr     (wr_ptr),
    .dout       (dout),
    .dout_valid (dout_valid)
);

// File: tb/tb_ram_delay_line.sv
// Scoreboard bench: the driver queues every word it sends, and the monitor
// pops and compares one word each cycle that the output is flagged valid.
module tb_ram_delay_line;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_valid;

    int checks = 0;
    int fails = 0;
    int edges = 0;
    bit done = 1'b0;
    string tag = "R7";
    logic [DATA_W-1:0] expq [$];

    ram_delay_line #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: present one word, queue it as expected, wait one cycle.
    task automatic drive_word(input logic [DATA_W-1:0] v);
        din = v;
        expq.push_back(v);
        @(negedge clk);
    endtask

    // Latency check: after each full cycle exactly DEPTH words are in flight (R4).
    task automatic check_in_flight();
        check(expq.size() == DEPTH, "R4", "words in flight",
              DATA_W'(expq.size()), DATA_W'(DEPTH));
    endtask

    // Hold reset for a few edges, then release at a falling edge.
    task automatic apply_reset(input int cycles);
        rst_n = 1'b0;
        expq.delete();
        repeat (cycles) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: sample a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            if (!rst_n) begin
                edges = 0;
                check(dout == '0, "R1", "dout in reset", dout, '0);
                check(!dout_valid, "R1", "valid in reset", DATA_W'(dout_valid), '0);
            end else begin
                edges++;
                // R5: valid after edge DEPTH, that is DEPTH+1 edges seen.
                check(dout_valid == (edges >= DEPTH + 1), "R5", "valid flag",
                      DATA_W'(dout_valid), DATA_W'(edges >= DEPTH + 1));
                if (dout_valid) begin
                    if (expq.size() == 0) begin
                        check(1'b0, tag, "scoreboard empty", dout, '0);
                    end else begin
                        logic [DATA_W-1:0] e;
                        e = expq.pop_front();
                        check(dout == e, tag, "dout vs shift model", dout, e);
                    end
                end
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] lfsr;
        repeat (3) @(negedge clk);
        apply_reset(1);

        // R2 R3: counting pattern across three wraps of the memory.
        tag = "R2 R3";
        for (int i = 0; i < 3 * DEPTH; i++) drive_word(DATA_W'(i * 7 + 1));
        check_in_flight();

        // R7: walking ones, all zeros and all ones.
        tag = "R7";
        for (int i = 0; i < DEPTH; i++) drive_word(DATA_W'(1) << (i % DATA_W));
        for (int i = 0; i < DEPTH / 2; i++) drive_word('0);
        for (int i = 0; i < DEPTH / 2; i++) drive_word('1);
        for (int i = 0; i < DEPTH; i++) drive_word((i % 2) ? 16'hA5A5 : 16'h5A5A);
        check_in_flight();

        // R6: reset in mid stream; old words must never come out valid.
        tag = "R6";
        apply_reset(4);
        for (int i = 0; i < DEPTH / 2; i++) drive_word(DATA_W'(16'hC000 + i));
        // R6: a second reset before the first pass ends restarts the fill.
        apply_reset(2);
        lfsr = 16'hACE1;
        for (int i = 0; i < 2 * DEPTH + 5; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive_word(lfsr);
        end
        check_in_flight();

        // R4: one more pass of distinct words, then confirm the latency again.
        tag = "R4";
        for (int i = 0; i < DEPTH + 3; i++) drive_word(DATA_W'(16'h3000 + i));
        check_in_flight();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule